// File: doc/BRIEF.md
# Trigger-Aligned Clock Regenerator

This block rebuilds a reference clock inside a fast system clock domain so that its phase starts over whenever a trigger input falls. The reference clock and the trigger are both oversampled by the system clock. The block keeps measuring how many system cycles the reference spends high and how many it spends low. When the trigger falls, it starts a fresh copy of the reference waveform built from those widths. The copy always opens with a low phase.

From this regenerated clock the block derives several outputs: the clock itself and its inverse, a divide-by-two copy and its inverse, a one-shot pulse about two reference periods long, and a clock that never stops. While the trigger is high, the regenerated outputs rest at fixed idle levels and the never-stopping clock passes the synchronized reference instead. A valid flag stays low from reset until the trigger has been seen high for the first time. The system clock must run at least eight times faster than the reference.

Top module: `trig_clk_regen`

## Requirements
- R1: While `rst` is high, and on the first edge after it, the outputs are `sync_clk`=0, `sync_clk_n`=1, `div_clk`=0, `div_clk_n`=1, `pulse_out`=0, `cont_clk`=0 and `out_valid`=0.
- R2: `out_valid` goes high after edge a+2, where a is the first edge at which `trig_in` is sampled high, and then stays high until reset. Before that, all outputs keep their R1 values.
- R3: Each high or low reference width is the number of system cycles the synchronized reference holds that level. If `trig_in` is sampled low at edge a after being sampled high at edge a-1, then `sync_clk` is low from after edge a+3 through edge a+LO+2 and high after edge a+LO+3. LO is the low width latched before the fall.
- R4: After its first rise, `sync_clk` repeats HI cycles high and LO cycles low, using the widths latched at the trigger fall. Later changes to the reference do not alter it until the next trigger fall.
- R5: `sync_clk_n` is always the complement of `sync_clk`.
- R6: `div_clk` is 0 when the waveform restarts and toggles on every rising edge of `sync_clk`, so the first rise sets it to 1. `div_clk_n` is always its complement.
- R7: `pulse_out` is high from after edge a+3 for exactly PULSE_PERIODS*(LO+HI) cycles, with a as in R3.
- R8: A new trigger fall restarts the waveform, the divider and the pulse timer, even while a pulse is still running.
- R9: If `trig_in` is sampled high at edge k, then after edge k+3 `sync_clk`, `div_clk` and `pulse_out` are 0 and their inverses are 1. After edge k+2, `cont_clk` equals `ref_clk_in` as sampled at edge k. When the trigger sampled at edge k is low, `cont_clk` after edge k+2 equals `sync_clk` at that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the reference frequency |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk_in | input | 1 | Reference clock, asynchronous to `clk` |
| trig_in | input | 1 | Trigger; its falling edge restarts the waveform |
| sync_clk | output | 1 | Regenerated clock aligned to the trigger |
| sync_clk_n | output | 1 | Complement of `sync_clk` |
| div_clk | output | 1 | Regenerated clock divided by two |
| div_clk_n | output | 1 | Complement of `div_clk` |
| pulse_out | output | 1 | One-shot pulse after each trigger fall |
| cont_clk | output | 1 | Clock that keeps running whatever the trigger level |
| out_valid | output | 1 | High once the trigger has been seen high |

## Verification
The hardest case to reach is a restart that lands while the previous waveform and pulse are still running, and does so with widths that were latched under a different reference shape. The stimulus changes the reference duty cycle while the trigger is high and again while it is low. It then drops one-cycle-high trigger blips into a live pulse, and sweeps the trigger gap so that falls land at many reference phase offsets. A behavioural model rebuilds each expected level from the cycle count since the last fall.

// File: rtl/trc_pkg.sv
package trc_pkg;
  typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} phase_e;

  typedef struct packed {
    logic level;
    logic rise;
    logic fall;
  } edge_t;
endpackage

// File: rtl/trc_edge_sync.sv
module trc_edge_sync
  import trc_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  async_in,
  output edge_t ev
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[STAGES-1:0], async_in};
  end

  assign ev.level = pipe[STAGES-1];
  assign ev.rise  = pipe[STAGES-1] & ~pipe[STAGES];
  assign ev.fall  = ~pipe[STAGES-1] & pipe[STAGES];
endmodule

// File: rtl/trc_width_meter.sv
module trc_width_meter
  import trc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  edge_t            ref_ev,
  output logic [CNT_W-1:0] lo_w,
  output logic [CNT_W-1:0] hi_w
);
  logic [CNT_W-1:0] run_cnt, lo_q, hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
    end else if (ref_ev.rise || ref_ev.fall) begin
      // The level now shown is the new one; the run just ended had the other level.
      if (ref_ev.level) lo_q <= run_cnt;
      else              hi_q <= run_cnt;
      run_cnt <= CNT_W'(1);
    end else if (run_cnt != '1) begin
      run_cnt <= run_cnt + CNT_W'(1);
    end
  end

  // A width of zero is never handed on; the minimum phase is one cycle.
  assign lo_w = (lo_q == '0) ? CNT_W'(1) : lo_q;
  assign hi_w = (hi_q == '0) ? CNT_W'(1) : hi_q;
endmodule

// File: rtl/trc_phase_gen.sv
module trc_phase_gen
  import trc_pkg::*;
#(
  parameter int CNT_W         = 8,
  parameter int PULSE_PERIODS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig_lvl,
  input  logic             trig_fall,
  input  logic [CNT_W-1:0] lo_w,
  input  logic [CNT_W-1:0] hi_w,
  output logic             phase_o,
  output logic             div_o,
  output logic             pulse_o
);
  localparam int TMR_W = CNT_W + 1 + $clog2(PULSE_PERIODS + 1);

  logic             gen_on;
  phase_e           ph;
  logic [CNT_W-1:0] rem, snap_lo, snap_hi;
  logic             div_q;
  logic [TMR_W-1:0] ptmr;
  logic [TMR_W-1:0] span;

  assign span = TMR_W'(PULSE_PERIODS) * (TMR_W'(lo_w) + TMR_W'(hi_w));

  always_ff @(posedge clk) begin
    if (rst) begin
      gen_on  <= 1'b0;
      ph      <= PH_LOW;
      rem     <= '0;
      snap_lo <= '0;
      snap_hi <= '0;
      div_q   <= 1'b0;
      ptmr    <= '0;
    end else if (trig_lvl) begin
      gen_on <= 1'b0;
      ph     <= PH_LOW;
      div_q  <= 1'b0;
      ptmr   <= '0;
    end else if (trig_fall) begin
      gen_on  <= 1'b1;
      ph      <= PH_LOW;
      rem     <= lo_w;
      snap_lo <= lo_w;
      snap_hi <= hi_w;
      div_q   <= 1'b0;
      ptmr    <= span;
    end else if (gen_on) begin
      if (rem == CNT_W'(1)) begin
        ph  <= (ph == PH_LOW) ? PH_HIGH : PH_LOW;
        rem <= (ph == PH_LOW) ? snap_hi : snap_lo;
        if (ph == PH_LOW) div_q <= ~div_q;
      end else begin
        rem <= rem - CNT_W'(1);
      end
      if (ptmr != '0) ptmr <= ptmr - TMR_W'(1);
    end
  end

  assign phase_o = (ph == PH_HIGH);
  assign div_o   = div_q;
  assign pulse_o = (ptmr != '0);
endmodule

// File: rtl/trig_clk_regen.sv
module trig_clk_regen
  import trc_pkg::*;
#(
  parameter int CNT_W         = 8,
  parameter int PULSE_PERIODS = 2,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_clk_in,
  input  logic trig_in,
  output logic sync_clk,
  output logic sync_clk_n,
  output logic div_clk,
  output logic div_clk_n,
  output logic pulse_out,
  output logic cont_clk,
  output logic out_valid
);
  localparam int N_IN     = 2;
  localparam int IDX_REF  = 0;
  localparam int IDX_TRIG = 1;

  logic [N_IN-1:0] raw_in;
  edge_t           ev [N_IN];
  logic [CNT_W-1:0] lo_w, hi_w;
  logic            gen_phase, gen_div, gen_pulse;
  logic            armed;
  logic            trig_lvl;

  assign raw_in   = {trig_in, ref_clk_in};
  assign trig_lvl = ev[IDX_TRIG].level;

  for (genvar g = 0; g < N_IN; g++) begin : g_sync
    trc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst      (rst),
      .async_in (raw_in[g]),
      .ev       (ev[g])
    );
  end

  trc_width_meter #(.CNT_W(CNT_W)) u_meter (
    .clk    (clk),
    .rst    (rst),
    .ref_ev (ev[IDX_REF]),
    .lo_w   (lo_w),
    .hi_w   (hi_w)
  );

  trc_phase_gen #(.CNT_W(CNT_W), .PULSE_PERIODS(PULSE_PERIODS)) u_gen (
    .clk       (clk),
    .rst       (rst),
    .trig_lvl  (trig_lvl),
    .trig_fall (ev[IDX_TRIG].fall),
    .lo_w      (lo_w),
    .hi_w      (hi_w),
    .phase_o   (gen_phase),
    .div_o     (gen_div),
    .pulse_o   (gen_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_clk   <= 1'b0;
      sync_clk_n <= 1'b1;
      div_clk    <= 1'b0;
      div_clk_n  <= 1'b1;
      pulse_out  <= 1'b0;
      cont_clk   <= 1'b0;
      armed      <= 1'b0;
    end else begin
      sync_clk   <= gen_phase;
      sync_clk_n <= ~gen_phase;
      div_clk    <= gen_div;
      div_clk_n  <= ~gen_div;
      pulse_out  <= gen_pulse;
      cont_clk   <= trig_lvl ? ev[IDX_REF].level : gen_phase;
      armed      <= armed | ev[IDX_TRIG].rise;
    end
  end

  assign out_valid = armed;
endmodule

// File: rtl/trc_checker.sv
module trc_checker (
  input logic clk,
  input logic rst,
  input logic trig_lvl,
  input logic sync_clk,
  input logic sync_clk_n,
  input logic div_clk,
  input logic div_clk_n,
  input logic pulse_out,
  input logic cont_clk,
  input logic out_valid
);
  p_inv_sync_r5: assert property (@(posedge clk) disable iff (rst)
    sync_clk_n == !sync_clk);

  p_inv_div_r6: assert property (@(posedge clk) disable iff (rst)
    div_clk_n == !div_clk);

  p_div_on_rise_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(div_clk) |-> $rose(sync_clk));

  p_idle_unarmed_r2: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!sync_clk && !div_clk && !pulse_out && !cont_clk));

  p_valid_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> out_valid);

  p_gated_r9: assert property (@(posedge clk) disable iff (rst)
    trig_lvl |-> ##2 (!sync_clk && !div_clk && !pulse_out));

  p_pulse_start_low_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse_out) |-> (!sync_clk && !div_clk));
endmodule

bind trig_clk_regen trc_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .trig_lvl   (trig_lvl),
  .sync_clk   (sync_clk),
  .sync_clk_n (sync_clk_n),
  .div_clk    (div_clk),
  .div_clk_n  (div_clk_n),
  .pulse_out  (pulse_out),
  .cont_clk   (cont_clk),
  .out_valid  (out_valid)
);

// File: tb/trig_clk_regen_tb_top.sv
module trig_clk_regen_tb_top;
  localparam int CNT_W    = 8;
  localparam int PP       = 2;
  localparam int WD_LIMIT = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_clk_in = 1'b0;
  logic trig_in = 1'b0;
  logic sync_clk, sync_clk_n, div_clk, div_clk_n, pulse_out, cont_clk, out_valid;

  trig_clk_regen #(.CNT_W(CNT_W), .PULSE_PERIODS(PP), .SYNC_STAGES(2)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .ref_clk_in (ref_clk_in),
    .trig_in    (trig_in),
    .sync_clk   (sync_clk),
    .sync_clk_n (sync_clk_n),
    .div_clk    (div_clk),
    .div_clk_n  (div_clk_n),
    .pulse_out  (pulse_out),
    .cont_clk   (cont_clk),
    .out_valid  (out_valid)
  );

  always #4 clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  bit    chk_en = 1'b0;
  bit    finished = 1'b0;
  int    cyc = 0;
  string tag = "R1";

  // Reference clock source: each level lasts a whole number of system cycles.
  int ref_hi = 5;
  int ref_lo = 5;
  int ref_cnt = 0;
  always @(negedge clk) begin
    if (rst) begin
      ref_clk_in = 1'b0;
      ref_cnt = 0;
    end else begin
      ref_cnt = ref_cnt + 1;
      if (ref_cnt >= (ref_clk_in ? ref_hi : ref_lo)) begin
        ref_clk_in = ~ref_clk_in;
        ref_cnt = 0;
      end
    end
  end

  // Behavioural reference model, evaluated at every rising edge.
  bit th [4];
  bit rh [3];
  int edge_n, run_len;
  int pend_lo, pend_hi, pend_lo_at, pend_hi_at;
  int wlo, whi, s_lo, s_hi, m_t;
  bit m_gen, m_valid, i_ph, i_div, i_pul;
  bit e_sync, e_div, e_pul, e_cont, e_valid;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) th[i] = 1'b0;
      for (int i = 0; i < 3; i++) rh[i] = 1'b0;
      edge_n = 0; run_len = 1;
      pend_lo_at = -1; pend_hi_at = -1; pend_lo = 0; pend_hi = 0;
      wlo = 0; whi = 0; s_lo = 1; s_hi = 1; m_t = 0;
      m_gen = 0; m_valid = 0; i_ph = 0; i_div = 0; i_pul = 0;
      e_sync = 0; e_div = 0; e_pul = 0; e_cont = 0; e_valid = 0;
    end else begin
      th[3] = th[2]; th[2] = th[1]; th[1] = th[0]; th[0] = trig_in;
      rh[2] = rh[1]; rh[1] = rh[0]; rh[0] = ref_clk_in;
      e_sync = i_ph;
      e_div  = i_div;
      e_pul  = i_pul;
      e_cont = th[2] ? rh[2] : i_ph;
      m_valid = m_valid | th[2];
      e_valid = m_valid;
      if (th[2]) m_gen = 0;
      else if (th[3]) begin
        m_gen = 1; m_t = 0;
        s_lo = (wlo == 0) ? 1 : wlo;
        s_hi = (whi == 0) ? 1 : whi;
      end else if (m_gen) m_t = m_t + 1;
      begin
        int per;
        per = s_lo + s_hi;
        i_ph  = m_gen && ((m_t % per) >= s_lo);
        i_div = m_gen && (m_t >= s_lo) && ((((m_t - s_lo) / per) % 2) == 0);
        i_pul = m_gen && (m_t < PP * per);
      end
      if (pend_lo_at == edge_n) wlo = pend_lo;
      if (pend_hi_at == edge_n) whi = pend_hi;
      if (rh[0] != rh[1]) begin
        if (rh[1]) begin pend_hi = run_len; pend_hi_at = edge_n + 2; end
        else       begin pend_lo = run_len; pend_lo_at = edge_n + 2; end
        run_len = 1;
      end else begin
        run_len = run_len + 1;
      end
      edge_n = edge_n + 1;
    end
  end

  task automatic chk(string req, string nm, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s [%s] actual %b expected %b at %0t", req, nm, tag, act, exp, $time);
    end
  endtask

  // Compare every output away from the active edge.
  always @(negedge clk) begin
    if (chk_en && !finished) begin
      chk(rst ? "R1" : "R3", "sync_clk",   sync_clk,   e_sync);
      chk(rst ? "R1" : "R5", "sync_clk_n", sync_clk_n, !e_sync);
      chk(rst ? "R1" : "R6", "div_clk",    div_clk,    e_div);
      chk(rst ? "R1" : "R6", "div_clk_n",  div_clk_n,  !e_div);
      chk(rst ? "R1" : "R7", "pulse_out",  pulse_out,  e_pul);
      chk(rst ? "R1" : "R9", "cont_clk",   cont_clk,   e_cont);
      chk(rst ? "R1" : "R2", "out_valid",  out_valid,  e_valid);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT && !finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected under %0d", cyc, WD_LIMIT);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic hold(bit v, int n);
    trig_in = v;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    // R1: reset levels checked while rst is high
    repeat (2) @(negedge clk);
    chk_en = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R2: trigger never high yet, outputs idle and valid low
    tag = "R2";
    hold(1'b0, 40);
    // R9: trigger high, continuous clock passes the reference
    tag = "R9";
    hold(1'b1, 40);
    // R3: first restart with a symmetric reference
    tag = "R3";
    hold(1'b0, 120);
    // R9 then R3: new duty cycle measured while gated
    tag = "R9";
    trig_in = 1'b1;
    ref_lo = 6; ref_hi = 3;
    repeat (50) @(negedge clk);
    tag = "R3";
    hold(1'b0, 100);
    // R4: reference changes while running, waveform keeps latched widths
    tag = "R4";
    ref_lo = 4; ref_hi = 7;
    hold(1'b0, 120);
    // R8: one-cycle trigger blips restart a live pulse
    tag = "R8";
    hold(1'b1, 1);
    hold(1'b0, 7);
    hold(1'b1, 1);
    hold(1'b0, 12);
    hold(1'b1, 1);
    hold(1'b0, 60);
    // R7 and R6: falls at sweeping phase offsets
    tag = "R7";
    for (int i = 0; i < 8; i++) begin
      hold(1'b1, 9 + i);
      hold(1'b0, 40 + 3 * i);
    end
    tag = "R6";
    ref_lo = 3; ref_hi = 5;
    hold(1'b1, 30);
    hold(1'b0, 150);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule